// File: doc/BRIEF.md
# Multiplexed Address/Status Bus Cycle Sequencer

This block runs one external memory or peripheral access at a time for an 8-bit processor core. A 16-bit address has to leave the chip over two sets of pins. The low twelve bits go on a dedicated address bus. The high four bits share the 8-bit data bus with four status bits, but only during an address phase that is framed by an active-low address strobe. A data phase follows in the same access. In that phase one byte moves over the same data bus, framed by either an active-low read strobe or an active-low write strobe.

Each phase lasts one microcycle. A microcycle is `PHASE_CLKS` periods of the base clock, four by default. The block never drives the data bus except while it asserts the address strobe or the write strobe. During the read strobe the external device drives the bus.

The core side is a valid/ready request channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so the core holds its request, with stable fields, until that edge. A request presented while a cycle is under way has no effect. The response is a one-clock `rsp_valid` pulse with no back-pressure: the core must take `rsp_rdata` in that clock.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, and whenever idle, `req_ready`=1, all three strobes are 1, `dbus_oe`=0 and `rsp_valid`=0. `req_ready` is 0 from the clock after acceptance until the cycle after the done pulse. An asynchronous reset during a cycle returns the block to this idle state at once.
- R2: The address strobe `ads_n` is 0 for exactly `PHASE_CLKS` clocks, starting in the clock after acceptance. `addr_bus` carries request address bits 11:0 from that clock through the end of the data phase.
- R3: During the address phase `dbus_oe`=1 and `dbus_out` = {status[3:0], address[15:12]}. Status is on data bits 7:4 and the address high nibble is on bits 3:0.
- R4: The data phase starts in the clock right after the address strobe rises and lasts `PHASE_CLKS` clocks. In it, `rds_n`=0 when `req_write` was 0, and `wds_n`=0 when `req_write` was 1.
- R5: During the write strobe `dbus_oe`=1 and `dbus_out` equals the accepted write byte.
- R6: `dbus_oe` is 0 whenever neither the address strobe nor the write strobe is low, including the whole read strobe.
- R7: Read data is sampled from `dbus_in` at the clock edge that ends the last clock of the read strobe. Values on `dbus_in` in earlier read clocks do not matter. The sampled byte is shown on `rsp_rdata` with the done pulse.
- R8: At most one of `ads_n`, `rds_n`, `wds_n` is 0 in any clock.
- R9: `rsp_valid` is 1 for exactly one clock, the clock right after the data strobe is released (clock 2*`PHASE_CLKS`+1 after acceptance). Changes on the request inputs while busy do not alter the bus outputs of the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 16 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Byte to write |
| req_status | input | 4 | Status nibble shown in the address phase |
| rsp_valid | output | 1 | One-clock done pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| addr_bus | output | 12 | Dedicated low address bus |
| dbus_in | input | 8 | Data bus as seen from the pins |
| dbus_out | output | 8 | Value to drive on the data bus |
| dbus_oe | output | 1 | Drive enable for the data bus (0 = high impedance) |
| ads_n | output | 1 | Address strobe, active low |
| rds_n | output | 1 | Read strobe, active low |
| wds_n | output | 1 | Write strobe, active low |

## Verification
The assertions assume that the core drops or renews `req_valid` only as the handshake rules say. They also assume that reset is the only event that cuts a cycle short. Under those conditions strobe exclusivity, the phase order, the hold of the low address and the single-clock done pulse follow from the inputs. The stimulus keeps request fields stable until acceptance. It changes them on purpose only while `req_ready` is 0, so the block is expected to ignore them. The bench drives a wrong byte on `dbus_in` in every read clock except the last, so a capture in the wrong clock shows up in `rsp_rdata`.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } bcs_state_e;

  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned LO_ADDR_W  = 12;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned STATUS_W   = 4;
  localparam int unsigned HI_ADDR_W  = ADDR_W - LO_ADDR_W;
endpackage

// File: rtl/bcs_phase_timer.sv
module bcs_phase_timer #(
  parameter int unsigned PHASE_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned CW = (PHASE_CLKS > 2) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(PHASE_CLKS - 1);

  logic [CW-1:0] cnt;

  assign last = run && (cnt == LAST_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || last) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R2
  idle_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       wr_q,
  input  logic       phase_last,
  output bcs_state_e state,
  output logic       req_ready,
  output logic       req_fire,
  output logic       phase_run
);
  bcs_state_e nxt;

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign phase_run = (state == ST_ADDR) || (state == ST_READ) || (state == ST_WRITE);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (req_fire) nxt = ST_ADDR;
      ST_ADDR:  if (phase_last) nxt = wr_q ? ST_WRITE : ST_READ;
      ST_READ,
      ST_WRITE: if (phase_last) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R9
  done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_IDLE));
endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_fire,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [STATUS_W-1:0]  req_status,
  input  bcs_state_e           state,
  input  logic                 phase_last,
  input  logic [DATA_W-1:0]    dbus_in,
  output logic                 wr_q,
  output logic [LO_ADDR_W-1:0] addr_bus,
  output logic [DATA_W-1:0]    dbus_out,
  output logic                 dbus_oe,
  output logic [DATA_W-1:0]    rdata
);
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [STATUS_W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      stat_q  <= '0;
    end else if (req_fire) begin
      addr_q  <= req_addr;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
      stat_q  <= req_status;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              rdata <= '0;
    else if ((state == ST_READ) && phase_last) rdata <= dbus_in;
  end

  assign addr_bus = addr_q[LO_ADDR_W-1:0];

  always_comb begin
    dbus_out = '0;
    dbus_oe  = 1'b0;
    unique case (state)
      ST_ADDR: begin
        dbus_out = {stat_q, addr_q[ADDR_W-1 -: HI_ADDR_W]};
        dbus_oe  = 1'b1;
      end
      ST_WRITE: begin
        dbus_out = wdata_q;
        dbus_oe  = 1'b1;
      end
      default: ;
    endcase
  end

  // R9
  busy_latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(addr_q));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int unsigned PHASE_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_addr,
  input  logic        req_write,
  input  logic [7:0]  req_wdata,
  input  logic [3:0]  req_status,
  output logic        rsp_valid,
  output logic [7:0]  rsp_rdata,
  output logic [11:0] addr_bus,
  input  logic [7:0]  dbus_in,
  output logic [7:0]  dbus_out,
  output logic        dbus_oe,
  output logic        ads_n,
  output logic        rds_n,
  output logic        wds_n
);
  bcs_state_e state;
  logic       req_fire;
  logic       phase_run;
  logic       phase_last;
  logic       wr_q;

  bcs_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (phase_run),
    .last  (phase_last)
  );

  bcs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .wr_q       (wr_q),
    .phase_last (phase_last),
    .state      (state),
    .req_ready  (req_ready),
    .req_fire   (req_fire),
    .phase_run  (phase_run)
  );

  bcs_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire   (req_fire),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .req_status (req_status),
    .state      (state),
    .phase_last (phase_last),
    .dbus_in    (dbus_in),
    .wr_q       (wr_q),
    .addr_bus   (addr_bus),
    .dbus_out   (dbus_out),
    .dbus_oe    (dbus_oe),
    .rdata      (rsp_rdata)
  );

  assign ads_n     = (state != ST_ADDR);
  assign rds_n     = (state != ST_READ);
  assign wds_n     = (state != ST_WRITE);
  assign rsp_valid = (state == ST_DONE);

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ads_n, ~rds_n, ~wds_n}) <= 1);

  // R6
  oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_oe |-> (!ads_n || !wds_n));

  // R4
  addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ads_n) |-> (!rds_n || !wds_n));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !ads_n));

  // R2
  abus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rds_n || !wds_n) |-> $stable(addr_bus));
endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic [3:0]  req_status = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [11:0] addr_bus;
  logic [7:0]  dbus_in = '0;
  logic [7:0]  dbus_out;
  logic        dbus_oe;
  logic        ads_n, rds_n, wds_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] last_rd = '0;

  always #10 clk = ~clk;

  bus_cycle_seq #(.PHASE_CLKS(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_status(req_status), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .addr_bus(addr_bus), .dbus_in(dbus_in), .dbus_out(dbus_out),
    .dbus_oe(dbus_oe), .ads_n(ads_n), .rds_n(rds_n), .wds_n(wds_n)
  );

  // fields: [36] write, [35:20] addr, [19:16] status, [15:8] wdata, [7:0] read byte
  localparam logic [36:0] VEC [6] = '{
    {1'b0, 16'h0123, 4'h5, 8'h00, 8'h3C},
    {1'b1, 16'hF456, 4'hA, 8'h9E, 8'h00},
    {1'b0, 16'hFFFF, 4'hF, 8'h00, 8'hFF},
    {1'b1, 16'h0000, 4'h0, 8'h00, 8'h00},
    {1'b0, 16'h8A5A, 4'h3, 8'h00, 8'h00},
    {1'b1, 16'h7FFF, 4'hC, 8'hFF, 8'h11}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " R1 idle strobes/oe/ready/rsp"},
        {28'd0, ads_n, rds_n, wds_n, req_ready},
        {28'd0, 4'b1111});
    chk({tag, " R1 idle oe"}, {31'd0, dbus_oe}, 32'd0);
    chk({tag, " R1 idle rsp_valid"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic run_cycle(input logic [36:0] v, input bit hold_valid);
    logic        wr;
    logic [15:0] ad;
    logic [3:0]  st;
    logic [7:0]  wd, rd;
    {wr, ad, st, wd, rd} = v;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_status = st; req_wdata = wd;
    @(posedge clk);
    for (int k = 1; k <= 2*P + 2; k++) begin
      @(negedge clk);
      if (hold_valid && k < 2*P + 1) begin
        req_addr = ~ad; req_status = ~st; req_wdata = ~wd; req_write = ~wr;
      end else begin
        req_valid = 1'b0;
      end
      dbus_in = (k == 2*P) ? rd : ~rd;
      if (k <= P) begin
        chk("R2 ads_n low", {31'd0, ads_n}, 32'd0);
        chk("R2 addr_bus", {20'd0, addr_bus}, {20'd0, ad[11:0]});
        chk("R3 dbus addr/status", {23'd0, dbus_oe, dbus_out}, {23'd0, 1'b1, st, ad[15:12]});
        chk("R8 data strobes high", {30'd0, rds_n, wds_n}, 32'd3);
        chk("R1 busy not ready", {31'd0, req_ready}, 32'd0);
      end else if (k <= 2*P) begin
        chk("R4 data strobe", {29'd0, ads_n, rds_n, wds_n}, {29'd0, 1'b1, wr, ~wr});
        chk("R2 addr_bus held", {20'd0, addr_bus}, {20'd0, ad[11:0]});
        if (wr) chk("R5 write drive", {23'd0, dbus_oe, dbus_out}, {23'd0, 1'b1, wd});
        else    chk("R6 read no drive", {31'd0, dbus_oe}, 32'd0);
        chk("R9 no early done", {31'd0, rsp_valid}, 32'd0);
      end else if (k == 2*P + 1) begin
        chk("R9 done pulse", {31'd0, rsp_valid}, 32'd1);
        chk("R6 strobes released oe", {28'd0, ads_n, rds_n, wds_n, dbus_oe}, {28'd0, 4'b1110});
        chk("R1 not ready at done", {31'd0, req_ready}, 32'd0);
        if (!wr) begin
          chk("R7 read capture", {24'd0, rsp_rdata}, {24'd0, rd});
          last_rd = rd;
        end else begin
          chk("R7 rdata kept on write", {24'd0, rsp_rdata}, {24'd0, last_rd});
        end
      end else begin
        chk("R9 single pulse", {31'd0, rsp_valid}, 32'd0);
        check_idle("post-cycle");
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #5;
    check_idle("in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("after reset");

    for (int i = 0; i < 6; i++) run_cycle(VEC[i], 1'b0);

    // request fields changed while busy must not disturb the cycle (R9, R1)
    run_cycle({1'b1, 16'hB2C3, 4'h6, 8'h5A, 8'h00}, 1'b1);
    run_cycle({1'b0, 16'h1E0F, 4'h9, 8'h00, 8'hC7}, 1'b1);

    // reset in the middle of a read data phase (R1)
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h4321; req_status = 4'h2;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (P + 1) @(negedge clk);
    chk("R4 read strobe before reset", {31'd0, rds_n}, 32'd0);
    rst_n = 1'b0;
    #1;
    check_idle("mid-cycle reset");
    chk("R1 rdata cleared", {24'd0, rsp_rdata}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    last_rd = 8'h00;
    @(negedge clk);
    check_idle("after mid reset");

    run_cycle({1'b0, 16'hC0DE, 4'h1, 8'h00, 8'h81}, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule